// File: doc/BRIEF.md
# DMA Chain Tag Sequencer

This block is the engine of a single DMA channel. In direct mode it streams a given number of 128-bit quadwords from a start address. In chained mode it reads a 128-bit descriptor tag from the tag pointer. It takes a quadword count, a kind code, a suspend-request bit and a jump address from the tag, and then streams that tag's payload. The tag kind decides where the payload sits and where the next tag is fetched from. A two-entry stack of return addresses supports subroutine-style descriptor lists.

The channel starts with `start_i`, which loads the count, the memory address and the tag pointer. It keeps running until the list ends, or until a tag with the suspend bit set has been served. After a suspension, `resume_i` carries on from the saved tag pointer. A shared priority-control gate (`pce_i` together with this channel's enable `cde_i`) can hold the channel before each tag fetch or before a direct transfer starts. The block reports the events that a shared control register must react to as pulses: `pce_set_o` on suspension and `pce_clr_o` on chain completion. Memory reads use a request/acknowledge port. Every acknowledged payload read also appears on the quadword output stream.

Top module: `dmaseq_chain_top`

## Requirements
- R1: After reset, str_o, qwc_o, madr_o, tadr_o, asr0_o, asr1_o, warn_o, mem_req_o and out_valid_o are all zero. No memory request is raised while str_o is low.
- R2: Direct mode (chain_i=0) emits exactly QWC beats, read from MADR, MADR+16, and so on. It ends with qwc_o=0, madr_o = start + 16*QWC, str_o low and one done_o pulse.
- R3: A direct transfer with QWC=0 completes without any memory read. It leaves qwc_o=0 and madr_o unchanged, clears str_o and pulses done_o.
- R4: A tag quadword is decoded from these fields: count in bits 15:0, kind in bits 30:28, suspend request in bit 31, and address in bits 63:32, with address bits 3:0 dropped. All other tag bits have no effect on the transfer.
- R5: Kind 0 (last-at-address), 3 and 4 (at-address) take their payload from the tag address. The next tag follows the current tag directly, and kind 0 ends the chain after its payload.
- R6: Kind 1 (inline-continue) and kind 2 (inline-jump) take their payload from the quadwords after the tag. For kind 1 the next tag follows the payload. For kind 2 the next tag is at the tag address.
- R7: Kind 5 (call) streams inline payload, pushes the address after the payload onto the stack (the old asr0_o moves to asr1_o) and jumps to the tag address. Kind 6 (return) streams inline payload and pops the stack into the tag pointer. A return with an empty stack ends the chain.
- R8: Kind 7 (stop) streams inline payload and ends the chain, even if its suspend bit is set.
- R9: While pce_i=1 and cde_i=0, an armed channel issues no memory read and keeps qwc_o, madr_o and tadr_o unchanged. Releasing the gate lets the transfer continue.
- R10: A tag with bit 31 set suspends the chain after its payload. str_o clears, qwc_o=0, madr_o points past the payload, tadr_o holds the next tag, pce_set_o pulses and done_o does not. resume_i then continues the chain.
- R11: When a chain ends normally, done_o and pce_clr_o pulse together and str_o clears.
- R12: A start or tag address with nonzero bits 3:0 is used with those bits cleared, and warn_o is set. The next start_i clears warn_o unless its own address is misaligned.
- R13: mem_req_o stays high with a stable mem_addr_o until mem_ack_i, and every requested address is 16-byte aligned.
- R14: start_i and resume_i have no effect while str_o is high. resume_i has no effect unless the channel is suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load count and addresses, then run |
| chain_i | input | 1 | 1 = chained descriptor mode, 0 = direct mode |
| qwc_i | input | CW | Initial quadword count |
| madr_i | input | AW | Initial data address |
| tadr_i | input | AW | Initial tag address |
| resume_i | input | 1 | Continue a suspended chain |
| pce_i | input | 1 | Priority-control gate active |
| cde_i | input | 1 | This channel allowed while the gate is active |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address (16-byte aligned) |
| mem_ack_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | DW | Read quadword |
| out_valid_o | output | 1 | Payload beat valid |
| out_data_o | output | DW | Payload quadword |
| str_o | output | 1 | Channel running |
| qwc_o | output | CW | Remaining quadword count |
| madr_o | output | AW | Current data address |
| tadr_o | output | AW | Current tag address |
| asr0_o | output | AW | Newest saved return address |
| asr1_o | output | AW | Older saved return address |
| done_o | output | 1 | Pulse: transfer or chain finished |
| pce_set_o | output | 1 | Pulse: suspension, gate should be set |
| pce_clr_o | output | 1 | Pulse: chain completion, gate should be cleared |
| warn_o | output | 1 | Misaligned address was truncated |

## Verification
A wrong next-tag choice or a corrupt stack entry shows up on the next tag read. The beat stream then carries quadwords from the wrong memory location, and the final tadr_o and madr_o differ from their arithmetic values within a few reads. A suspension in the middle of a call sequence exposes asr0_o, asr1_o and tadr_o directly at the ports. Count or address slips show up in the number of beats and in the final madr_o as soon as a direct transfer ends.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    // Tag kind codes (bits 30:28 of the tag), values fixed by the tag format
    typedef enum logic [2:0] {
        TK_LAST_AT  = 3'd0,
        TK_INL_CONT = 3'd1,
        TK_INL_JUMP = 3'd2,
        TK_AT       = 3'd3,
        TK_AT_S     = 3'd4,
        TK_CALL     = 3'd5,
        TK_RETURN   = 3'd6,
        TK_STOP     = 3'd7
    } tag_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_TAG,
        ST_DATA,
        ST_STEP,
        ST_FINISH
    } seq_state_e;

    localparam int ALIGN_BITS = 4;

endpackage

// File: rtl/dmaseq_tag_decode.sv
module dmaseq_tag_decode
    import dmaseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_field_i,
    input  logic [3:0]    ctl_field_i,
    input  logic [AW-1:0] addr_field_i,
    output logic [CW-1:0] qwc_o,
    output tag_kind_e     kind_o,
    output logic          irq_o,
    output logic [AW-1:0] addr_o,
    output logic          addr_misal_o,
    output logic          data_at_addr_o,
    output logic          addr_used_o
);
    always_comb begin
        qwc_o          = cnt_field_i;
        kind_o         = tag_kind_e'(ctl_field_i[2:0]);
        irq_o          = ctl_field_i[3];
        addr_o         = {addr_field_i[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        addr_misal_o   = |addr_field_i[ALIGN_BITS-1:0];
        data_at_addr_o = (kind_o == TK_LAST_AT) || (kind_o == TK_AT) || (kind_o == TK_AT_S);
        addr_used_o    = data_at_addr_o || (kind_o == TK_INL_JUMP) || (kind_o == TK_CALL);
    end
endmodule

// File: rtl/dmaseq_ret_stack.sv
module dmaseq_ret_stack #(
    parameter int AW = 32,
    parameter int SD = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 push_i,
    input  logic                 pop_i,
    input  logic [AW-1:0]        push_addr_i,
    output logic [AW-1:0]        top_o,
    output logic                 empty_o,
    output logic [SD-1:0][AW-1:0] ent_o
);
    localparam int DW_CNT = $clog2(SD + 1);
    localparam logic [DW_CNT-1:0] FULL = DW_CNT'(SD);

    typedef struct packed {
        logic [SD-1:0][AW-1:0] ent;
        logic [DW_CNT-1:0]     depth;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.ent   = '0;
            s_d.depth = '0;
        end else if (push_i) begin
            for (int i = SD - 1; i > 0; i--) s_d.ent[i] = s_q.ent[i-1];
            s_d.ent[0] = push_addr_i;
            s_d.depth  = (s_q.depth == FULL) ? FULL : s_q.depth + 1'b1;
        end else if (pop_i && s_q.depth != '0) begin
            for (int i = 0; i < SD - 1; i++) s_d.ent[i] = s_q.ent[i+1];
            s_d.ent[SD-1] = '0;
            s_d.depth     = s_q.depth - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign top_o   = s_q.ent[0];
    assign empty_o = (s_q.depth == '0);
    assign ent_o   = s_q.ent;

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.depth <= FULL);
    assert_push_pop_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> s_q.depth != '0);
endmodule

// File: rtl/dmaseq_chain_top.sv
module dmaseq_chain_top
    import dmaseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 128,
    parameter int SD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          chain_i,
    input  logic [CW-1:0] qwc_i,
    input  logic [AW-1:0] madr_i,
    input  logic [AW-1:0] tadr_i,
    input  logic          resume_i,
    input  logic          pce_i,
    input  logic          cde_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          out_valid_o,
    output logic [DW-1:0] out_data_o,
    output logic          str_o,
    output logic [CW-1:0] qwc_o,
    output logic [AW-1:0] madr_o,
    output logic [AW-1:0] tadr_o,
    output logic [AW-1:0] asr0_o,
    output logic [AW-1:0] asr1_o,
    output logic          done_o,
    output logic          pce_set_o,
    output logic          pce_clr_o,
    output logic          warn_o
);
    localparam logic [AW-1:0] QW_STEP = AW'(1 << ALIGN_BITS);
    localparam logic [CW-1:0] ONE_QW  = CW'(1);

    typedef struct packed {
        seq_state_e    st;
        logic          str;
        logic          chain;
        logic          susp;
        logic [CW-1:0] qwc;
        logic [AW-1:0] madr;
        logic [AW-1:0] tadr;
        logic [AW-1:0] jump;
        tag_kind_e     kind;
        logic          irq;
        logic          warn;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    function automatic logic [AW-1:0] align_qw(input logic [AW-1:0] a);
        return {a[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

    // tag field decode
    logic [CW-1:0] dec_qwc;
    tag_kind_e     dec_kind;
    logic          dec_irq, dec_misal, dec_at_addr, dec_addr_used;
    logic [AW-1:0] dec_addr;

    dmaseq_tag_decode #(.AW(AW), .CW(CW)) u_dec (
        .cnt_field_i   (mem_rdata_i[CW-1:0]),
        .ctl_field_i   (mem_rdata_i[31:28]),
        .addr_field_i  (mem_rdata_i[32 +: AW]),
        .qwc_o         (dec_qwc),
        .kind_o        (dec_kind),
        .irq_o         (dec_irq),
        .addr_o        (dec_addr),
        .addr_misal_o  (dec_misal),
        .data_at_addr_o(dec_at_addr),
        .addr_used_o   (dec_addr_used)
    );

    // return address stack
    logic                  stk_clr, stk_push, stk_pop, stk_empty;
    logic [AW-1:0]         stk_top;
    logic [SD-1:0][AW-1:0] stk_ent;

    dmaseq_ret_stack #(.AW(AW), .SD(SD)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (stk_clr),
        .push_i     (stk_push),
        .pop_i      (stk_pop),
        .push_addr_i(r_q.madr),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .ent_o      (stk_ent)
    );

    generate
        if (SD >= 2) begin : g_two
            assign asr1_o = stk_ent[1];
        end else begin : g_one
            assign asr1_o = '0;
        end
    endgenerate
    assign asr0_o = stk_ent[0];

    logic gate_open;
    logic finish_chain;
    assign gate_open = !(pce_i && !cde_i);

    always_comb begin
        r_d          = r_q;
        mem_req_o    = 1'b0;
        mem_addr_o   = '0;
        out_valid_o  = 1'b0;
        done_o       = 1'b0;
        pce_set_o    = 1'b0;
        pce_clr_o    = 1'b0;
        stk_clr      = 1'b0;
        stk_push     = 1'b0;
        stk_pop      = 1'b0;
        finish_chain = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.chain = chain_i;
                    r_d.qwc   = qwc_i;
                    r_d.madr  = align_qw(madr_i);
                    r_d.tadr  = align_qw(tadr_i);
                    r_d.warn  = chain_i ? |tadr_i[ALIGN_BITS-1:0] : |madr_i[ALIGN_BITS-1:0];
                    r_d.susp  = 1'b0;
                    r_d.str   = 1'b1;
                    r_d.st    = ST_ARM;
                    stk_clr   = chain_i;
                end else if (resume_i && r_q.susp) begin
                    r_d.susp = 1'b0;
                    r_d.str  = 1'b1;
                    r_d.st   = ST_ARM;
                end
            end

            ST_ARM: begin
                if (gate_open) begin
                    if (r_q.chain)          r_d.st = ST_TAG;
                    else if (r_q.qwc == '0) r_d.st = ST_FINISH;
                    else                    r_d.st = ST_DATA;
                end
            end

            ST_TAG: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.tadr;
                if (mem_ack_i) begin
                    r_d.qwc  = dec_qwc;
                    r_d.kind = dec_kind;
                    r_d.irq  = dec_irq;
                    r_d.jump = dec_addr;
                    r_d.warn = r_q.warn | (dec_misal && dec_addr_used);
                    r_d.madr = dec_at_addr ? dec_addr : r_q.tadr + QW_STEP;
                    r_d.st   = (dec_qwc == '0) ? ST_STEP : ST_DATA;
                end
            end

            ST_DATA: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.madr;
                if (mem_ack_i) begin
                    out_valid_o = 1'b1;
                    r_d.madr    = r_q.madr + QW_STEP;
                    r_d.qwc     = r_q.qwc - ONE_QW;
                    if (r_q.qwc == ONE_QW)
                        r_d.st = r_q.chain ? ST_STEP : ST_FINISH;
                end
            end

            ST_STEP: begin
                unique case (r_q.kind)
                    TK_LAST_AT: begin
                        r_d.tadr     = r_q.tadr + QW_STEP;
                        finish_chain = 1'b1;
                    end
                    TK_INL_CONT: r_d.tadr = r_q.madr;
                    TK_INL_JUMP: r_d.tadr = r_q.jump;
                    TK_AT, TK_AT_S: r_d.tadr = r_q.tadr + QW_STEP;
                    TK_CALL: begin
                        r_d.tadr = r_q.jump;
                        stk_push = 1'b1;
                    end
                    TK_RETURN: begin
                        if (!stk_empty) begin
                            r_d.tadr = stk_top;
                            stk_pop  = 1'b1;
                        end else begin
                            r_d.tadr     = r_q.madr;
                            finish_chain = 1'b1;
                        end
                    end
                    TK_STOP: begin
                        r_d.tadr     = r_q.madr;
                        finish_chain = 1'b1;
                    end
                endcase
                if (finish_chain) begin
                    r_d.st = ST_FINISH;
                end else if (r_q.irq) begin
                    r_d.str   = 1'b0;
                    r_d.susp  = 1'b1;
                    pce_set_o = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.st = ST_ARM;
                end
            end

            ST_FINISH: begin
                r_d.str   = 1'b0;
                done_o    = 1'b1;
                pce_clr_o = r_q.chain;
                r_d.st    = ST_IDLE;
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.kind <= TK_LAST_AT;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data_o = mem_rdata_i;
    assign str_o      = r_q.str;
    assign qwc_o      = r_q.qwc;
    assign madr_o     = r_q.madr;
    assign tadr_o     = r_q.tadr;
    assign warn_o     = r_q.warn;

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
    assert_addr_aligned_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[ALIGN_BITS-1:0] == '0));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !str_o |-> !mem_req_o);
    assert_gate_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (str_o && !mem_req_o && pce_i && !cde_i) |=> !mem_req_o);
    assert_beat_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (mem_req_o && mem_ack_i));
    assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!str_o && qwc_o == '0));
    assert_suspend_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pce_set_o |=> (!str_o && qwc_o == '0 && !done_o));
    assert_clr_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pce_clr_o |-> done_o);
endmodule

// File: tb/dmaseq_chain_top_tb.sv
module dmaseq_chain_top_tb;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          start_i = 0, chain_i = 0, resume_i = 0, pce_i = 0, cde_i = 1;
    logic [CW-1:0] qwc_i = '0;
    logic [AW-1:0] madr_i = '0, tadr_i = '0;
    logic          mem_req_o, out_valid_o, str_o, done_o, pce_set_o, pce_clr_o, warn_o;
    logic [AW-1:0] mem_addr_o, madr_o, tadr_o, asr0_o, asr1_o;
    logic [CW-1:0] qwc_o;
    logic [DW-1:0] out_data_o;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    dmaseq_chain_top #(.AW(AW), .CW(CW), .DW(DW), .SD(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chain_i(chain_i), .qwc_i(qwc_i),
        .madr_i(madr_i), .tadr_i(tadr_i), .resume_i(resume_i), .pce_i(pce_i), .cde_i(cde_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .str_o(str_o), .qwc_o(qwc_o), .madr_o(madr_o), .tadr_o(tadr_o), .asr0_o(asr0_o),
        .asr1_o(asr1_o), .done_o(done_o), .pce_set_o(pce_set_o), .pce_clr_o(pce_clr_o),
        .warn_o(warn_o)
    );

    logic [DW-1:0] mem [64];
    logic [DW-1:0] obuf [32];
    int ocnt = 0, reads = 0, n_done = 0, n_pset = 0, n_pclr = 0;
    int n_chk = 0, n_fail = 0;

    function automatic logic [DW-1:0] pat(input int i);
        return {32'hC0DE_0000 + 32'(i), 32'hA500_0000 + 32'(i), ~32'(i), 32'(i)};
    endfunction

    // tag: irq bit31, kind 30:28, filler in 27:16, count 15:0, addr in 63:32
    function automatic logic [DW-1:0] mk_tag(input int cnt, input int kind, input bit irq,
                                             input logic [31:0] addr);
        return {32'hDEAD_BEEF, 32'h5A5A_1234, addr, irq, 3'(kind), 2'b11, 10'h2C5, 16'(cnt)};
    endfunction

    function automatic logic [31:0] qa(input int i);
        return 32'(i * 16);
    endfunction

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack   <= mem_req_o && !mem_ack;
        mem_rdata <= mem[mem_addr_o[9:4]];
    end

    // output monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (out_valid_o && ocnt < 32) begin obuf[ocnt] <= out_data_o; ocnt <= ocnt + 1; end
            if (mem_req_o && mem_ack) reads <= reads + 1;
            if (done_o) n_done <= n_done + 1;
            if (pce_set_o) n_pset <= n_pset + 1;
            if (pce_clr_o) n_pclr <= n_pclr + 1;
        end
    end

    task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        ocnt = 0; reads = 0; n_done = 0; n_pset = 0; n_pclr = 0;
    endtask

    task automatic do_start(input bit ch, input int cnt, input logic [31:0] ma,
                            input logic [31:0] ta);
        @(negedge clk);
        chain_i = ch; qwc_i = 16'(cnt); madr_i = ma; tadr_i = ta; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_stop();
        for (int k = 0; k < 2000 && str_o; k++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 str", DW'(str_o), 0);
        check("R1 qwc", DW'(qwc_o), 0);
        check("R1 madr/tadr", DW'({madr_o, tadr_o}), 0);
        check("R1 asr", DW'({asr0_o, asr1_o}), 0);
        check("R1 req/valid/warn", DW'({mem_req_o, out_valid_o, warn_o}), 0);
        rst_n = 1'b1;

        // R2 / R3 direct sweep
        foreach (mem[b]) begin
            if (b == 2 || b == 7 || b == 20) begin
                for (int n = 0; n <= 6; n++) begin
                    clear_mon();
                    do_start(1'b0, n, qa(b), 32'h0);
                    wait_stop();
                    check(n == 0 ? "R3 beats" : "R2 beats", DW'(ocnt), DW'(n));
                    check(n == 0 ? "R3 reads" : "R2 reads", DW'(reads), DW'(n));
                    for (int k = 0; k < n; k++) check("R2 data", obuf[k], pat(b + k));
                    check("R2 qwc", DW'(qwc_o), 0);
                    check(n == 0 ? "R3 madr" : "R2 madr", DW'(madr_o), DW'(qa(b + n)));
                    check("R2 done", DW'({str_o, 31'(n_done)}), 1);
                end
            end
        end

        // R12 misaligned direct start
        clear_mon();
        do_start(1'b0, 2, qa(3) + 5, 32'h0);
        wait_stop();
        check("R12 data0", obuf[0], pat(3));
        check("R12 data1", obuf[1], pat(4));
        check("R12 madr", DW'(madr_o), DW'(qa(5)));
        check("R12 warn set", DW'(warn_o), 1);
        clear_mon();
        do_start(1'b0, 1, qa(3), 32'h0);
        wait_stop();
        check("R12 warn cleared", DW'(warn_o), 0);

        // R14 start/resume while running
        clear_mon();
        do_start(1'b0, 4, qa(2), 32'h0);
        @(negedge clk);
        qwc_i = 9; madr_i = qa(30); start_i = 1'b1; resume_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; resume_i = 1'b0;
        wait_stop();
        check("R14 beats", DW'(ocnt), 4);
        check("R14 madr", DW'(madr_o), DW'(qa(6)));
        @(negedge clk); resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
        @(negedge clk);
        check("R14 resume ignored", DW'({str_o, mem_req_o}), 0);

        // chained list, all tags carry filler bits (R4)
        mem[10] = mk_tag(2, 1, 0, 32'h0);
        mem[13] = mk_tag(1, 2, 0, qa(20));
        mem[20] = mk_tag(2, 3, 0, qa(30));
        mem[21] = mk_tag(1, 4, 0, qa(33));
        mem[22] = mk_tag(1, 5, 0, qa(40));
        mem[40] = mk_tag(0, 5, 1, qa(45));
        mem[45] = mk_tag(1, 6, 0, 32'h0);
        mem[41] = mk_tag(0, 6, 0, 32'h0);
        mem[24] = mk_tag(1, 7, 0, 32'h0);

        // R9 gate hold
        clear_mon();
        pce_i = 1'b1; cde_i = 1'b0;
        do_start(1'b1, 51, 32'h0, qa(10));
        repeat (20) @(negedge clk);
        check("R9 held str", DW'(str_o), 1);
        check("R9 held qwc", DW'(qwc_o), 51);
        check("R9 held reads", DW'(reads), 0);
        check("R9 held tadr", DW'(tadr_o), DW'(qa(10)));
        pce_i = 1'b0; cde_i = 1'b1;
        wait_stop();

        // R10 suspension inside the call sequence
        check("R10 str", DW'(str_o), 0);
        check("R10 qwc", DW'(qwc_o), 0);
        check("R10 madr", DW'(madr_o), DW'(qa(41)));
        check("R10 tadr", DW'(tadr_o), DW'(qa(45)));
        check("R10 pce_set/done", DW'({16'(n_pset), 16'(n_done)}), DW'({16'd1, 16'd0}));
        check("R7 asr0", DW'(asr0_o), DW'(qa(41)));
        check("R7 asr1", DW'(asr1_o), DW'(qa(24)));
        check("R6 beats pre", DW'(ocnt), 7);
        check("R6 cnt data", obuf[0], pat(11));
        check("R6 cnt data2", obuf[1], pat(12));
        check("R6 next data", obuf[2], pat(14));
        check("R5 ref data", obuf[3], pat(30));
        check("R5 ref data2", obuf[4], pat(31));
        check("R5 refs data", obuf[5], pat(33));
        check("R7 call data", obuf[6], pat(23));
        @(negedge clk); resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
        wait_stop();
        check("R10 resumed beats", DW'(ocnt), 9);
        check("R7 ret data", obuf[7], pat(46));
        check("R8 end data", obuf[8], pat(25));
        check("R8 madr", DW'(madr_o), DW'(qa(26)));
        check("R8 tadr", DW'(tadr_o), DW'(qa(26)));
        check("R7 stack drained", DW'({asr0_o, asr1_o}), 0);
        check("R11 done/clr", DW'({16'(n_done), 16'(n_pclr)}), DW'({16'd1, 16'd1}));
        check("R11 str/qwc", DW'({str_o, qwc_o}), 0);

        // R5 last-at-address with misaligned address (R12)
        mem[50] = mk_tag(2, 0, 0, qa(52) + 4);
        clear_mon();
        do_start(1'b1, 0, 32'h0, qa(50));
        wait_stop();
        check("R5 refe beats", DW'(ocnt), 2);
        check("R5 refe data", obuf[0], pat(52));
        check("R5 refe data2", obuf[1], pat(53));
        check("R5 refe tadr", DW'(tadr_o), DW'(qa(51)));
        check("R12 tag warn", DW'(warn_o), 1);
        check("R11 refe done", DW'({16'(n_done), 16'(n_pclr)}), DW'({16'd1, 16'd1}));

        // R7 return on empty stack ends the chain
        mem[55] = mk_tag(1, 6, 0, 32'h0);
        clear_mon();
        do_start(1'b1, 0, 32'h0, qa(55));
        wait_stop();
        check("R7 empty ret beats", DW'(ocnt), 1);
        check("R7 empty ret data", obuf[0], pat(56));
        check("R7 empty ret done", DW'(n_done), 1);
        check("R12 aligned tag no warn", DW'(warn_o), 0);

        // R8 stop tag with suspend bit still ends
        mem[58] = mk_tag(1, 7, 1, 32'h0);
        clear_mon();
        do_start(1'b1, 0, 32'h0, qa(58));
        wait_stop();
        check("R8 end beats", DW'(ocnt), 1);
        check("R8 end data", obuf[0], pat(59));
        check("R8 no suspend", DW'({16'(n_done), 16'(n_pset)}), DW'({16'd1, 16'd0}));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule